// File: doc/BRIEF.md
# Destination Address Filter

This block watches a byte stream of incoming network frames and decides, for each frame, whether the frame is meant for this station. The first six bytes of a frame hold its destination address. The block compares that address with three kinds of target at the same time: the station's own unique address, a small table of programmable multicast entries (each entry with its own enable), and the broadcast address.

One cycle after the sixth destination byte arrives, the block reports its decision. The report holds the accept flag, the class of the match and the full 48-bit destination. After an accepted frame, each following byte is passed out with a tag. The tag shows whether the byte belongs to the source address, the length field or the payload, and a separate strobe marks payload bytes bound for buffer storage. A rejected frame produces no output after its decision until the next start of frame.

A downstream store uses the decision and the destination word, the tagged header bytes and the payload strobe to build the received frame.

Top module: `dst_addr_filter`

## Requirements
- R1: After synchronous reset, every output is zero: dec_valid, dec_accept, dec_class, dec_addr, out_valid, out_tag, out_data and payload_valid.
- R2: A frame is accepted when its destination equals cfg_station. On the clock edge that samples the sixth destination byte, dec_valid rises for one cycle with dec_accept=1, dec_class=1 (unique) and dec_addr holding the destination.
- R3: A frame is accepted with dec_class=2 (multicast) when its destination equals multicast entry k, held in cfg_mcast[48k+47:48k], and cfg_mcast_en[k] is 1. An entry whose enable bit is 0 never matches.
- R4: A frame whose destination is all ones (48'hFFFF_FFFF_FFFF) is accepted with dec_class=3 (broadcast).
- R5: A frame that matches no class gives dec_valid with dec_accept=0 and dec_class=0. After that it raises no out_valid and no payload_valid until the next start of frame.
- R6: When several classes match, dec_class reports unique first, then broadcast, then multicast.
- R7: For an accepted frame, each later byte appears on out_data with out_valid one cycle after it is sampled. Frame bytes 6 to 11 are tagged 1 (source), bytes 12 to 13 are tagged 2 (length), and every byte from 14 on is tagged 3 (payload).
- R8: payload_valid is 1 exactly when out_valid is 1 and out_tag is 3.
- R9: A byte with in_valid and in_sof both high is byte 0 of a new frame at any point, even in the middle of another frame.
- R10: A cycle with in_valid low moves no frame position forward and produces no output.
- R11: The first destination byte of a frame is the most significant byte of the address (bits 47:40), and the sixth byte is bits 7:0.
- R12: dec_valid pulses at most once per frame. A frame shorter than six bytes produces no decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A byte is present on in_data |
| in_sof | input | 1 | The present byte is the first byte of a frame |
| in_data | input | 8 | Frame byte |
| cfg_station | input | 48 | Station unique address |
| cfg_mcast | input | 48*NUM_MC | Multicast entries, entry k at bits 48k+47:48k |
| cfg_mcast_en | input | NUM_MC | Per-entry multicast enable |
| dec_valid | output | 1 | Single-cycle decision strobe |
| dec_accept | output | 1 | Frame accepted |
| dec_class | output | 2 | 0 none, 1 unique, 2 multicast, 3 broadcast |
| dec_addr | output | 48 | Destination address of the decided frame |
| out_valid | output | 1 | Byte of an accepted frame present on out_data |
| out_tag | output | 2 | 1 source, 2 length, 3 payload |
| out_data | output | 8 | Passed-through byte |
| payload_valid | output | 1 | Present byte is payload |

## Verification
The assertions assume that the configuration inputs stay steady while a frame's destination is arriving. They also assume that in_sof has meaning only when in_valid is high. The bench changes cfg_station, cfg_mcast and cfg_mcast_en only between frames, while in_valid is low. It raises in_sof only together with in_valid, and it drives every byte half a cycle away from the sampling edge. The bench also inserts gaps with in_valid low and restarts frames in the middle, so that the frame position counter and the reject hold are tested under stalls and restarts.

// File: rtl/daf_pkg.sv
package daf_pkg;
    localparam int BYTE_W    = 8;
    localparam int ADDR_W    = 48;
    localparam int DST_BYTES = ADDR_W / BYTE_W;
    localparam int SRC_BYTES = 6;
    localparam int LEN_BYTES = 2;
    localparam int SRC_END   = DST_BYTES + SRC_BYTES;
    localparam int PAY_START = SRC_END + LEN_BYTES;
    localparam int IDX_W     = $clog2(PAY_START + 1);
    localparam int SR_W      = (DST_BYTES - 1) * BYTE_W;

    typedef enum logic [1:0] {
        TAG_DST = 2'd0,
        TAG_SRC = 2'd1,
        TAG_LEN = 2'd2,
        TAG_PAY = 2'd3
    } field_tag_e;

    typedef enum logic [1:0] {
        HIT_NONE   = 2'd0,
        HIT_UNIQUE = 2'd1,
        HIT_MULTI  = 2'd2,
        HIT_BCAST  = 2'd3
    } hit_class_e;

    typedef enum logic [1:0] {
        FR_IDLE = 2'd0,
        FR_DEST = 2'd1,
        FR_PASS = 2'd2
    } frame_state_e;

    typedef struct packed {
        logic              valid;
        logic              accept;
        hit_class_e        cls;
        logic [ADDR_W-1:0] addr;
    } decision_t;

    typedef struct packed {
        logic              valid;
        field_tag_e        tag;
        logic [BYTE_W-1:0] data;
    } beat_t;

    function automatic field_tag_e tag_of(input logic [IDX_W-1:0] idx);
        if (idx < IDX_W'(DST_BYTES))      return TAG_DST;
        else if (idx < IDX_W'(SRC_END))   return TAG_SRC;
        else if (idx < IDX_W'(PAY_START)) return TAG_LEN;
        else                              return TAG_PAY;
    endfunction

    function automatic hit_class_e pick_class(input logic uni, input logic bc, input logic mc);
        if (uni)     return HIT_UNIQUE;
        else if (bc) return HIT_BCAST;
        else if (mc) return HIT_MULTI;
        else         return HIT_NONE;
    endfunction
endpackage

// File: rtl/daf_cmp.sv
module daf_cmp
    import daf_pkg::*;
#(
    parameter int NUM_MC = 4
) (
    input  logic [ADDR_W-1:0]        addr,
    input  logic [ADDR_W-1:0]        station,
    input  logic [NUM_MC*ADDR_W-1:0] mcast,
    input  logic [NUM_MC-1:0]        mcast_en,
    output hit_class_e               cls,
    output logic                     accept
);
    logic [NUM_MC-1:0] mc_hit;
    logic              uni_hit;
    logic              bc_hit;

    genvar k;
    generate
        for (k = 0; k < NUM_MC; k++) begin : g_entry
            assign mc_hit[k] = mcast_en[k] && (mcast[k*ADDR_W +: ADDR_W] == addr);
        end
    endgenerate

    assign uni_hit = (addr == station);
    assign bc_hit  = &addr;
    assign cls     = pick_class(uni_hit, bc_hit, |mc_hit);
    assign accept  = (cls != HIT_NONE);
endmodule

// File: rtl/daf_seq.sv
module daf_seq
    import daf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              in_sof,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              accept_now,
    output logic              last_dst,
    output logic [ADDR_W-1:0] cand_addr,
    output beat_t             pass_beat
);
    frame_state_e     state_q;
    logic [IDX_W-1:0] idx_q;
    logic [SR_W-1:0]  sr_q;
    logic             start;
    logic             live;

    assign start     = in_valid && in_sof;
    assign live      = in_valid && !in_sof && (state_q != FR_IDLE);
    assign last_dst  = live && (state_q == FR_DEST) && (idx_q == IDX_W'(DST_BYTES - 1));
    assign cand_addr = {sr_q, in_data};

    always_comb begin
        pass_beat       = '0;
        pass_beat.valid = live && (state_q == FR_PASS);
        pass_beat.tag   = tag_of(idx_q);
        pass_beat.data  = in_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= FR_IDLE;
            idx_q   <= '0;
            sr_q    <= '0;
        end else if (start) begin
            state_q <= FR_DEST;
            idx_q   <= IDX_W'(1);
            sr_q    <= {sr_q[SR_W-BYTE_W-1:0], in_data};
        end else if (live) begin
            if (state_q == FR_DEST)
                sr_q <= {sr_q[SR_W-BYTE_W-1:0], in_data};
            if (last_dst)
                state_q <= accept_now ? FR_PASS : FR_IDLE;
            if (idx_q < IDX_W'(PAY_START))
                idx_q <= idx_q + IDX_W'(1);
        end
    end

    // R5
    rej_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (last_dst && !accept_now) |=> (state_q == FR_IDLE));

    // R12
    dec_once_chk: assert property (@(posedge clk) disable iff (rst)
        last_dst |=> !last_dst);

    // R7
    idx_sat_chk: assert property (@(posedge clk) disable iff (rst)
        idx_q <= IDX_W'(PAY_START));

    // R10
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(idx_q) && $stable(state_q)));
endmodule

// File: rtl/dst_addr_filter.sv
module dst_addr_filter
    import daf_pkg::*;
#(
    parameter int NUM_MC = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic                     in_sof,
    input  logic [7:0]               in_data,
    input  logic [47:0]              cfg_station,
    input  logic [NUM_MC*48-1:0]     cfg_mcast,
    input  logic [NUM_MC-1:0]        cfg_mcast_en,
    output logic                     dec_valid,
    output logic                     dec_accept,
    output logic [1:0]               dec_class,
    output logic [47:0]              dec_addr,
    output logic                     out_valid,
    output logic [1:0]               out_tag,
    output logic [7:0]               out_data,
    output logic                     payload_valid
);
    logic              last_dst;
    logic [ADDR_W-1:0] cand_addr;
    beat_t             pass_beat;
    hit_class_e        cls;
    logic              accept_now;
    decision_t         dec_q;
    beat_t             beat_q;
    logic              pay_q;

    daf_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_sof    (in_sof),
        .in_data   (in_data),
        .accept_now(accept_now),
        .last_dst  (last_dst),
        .cand_addr (cand_addr),
        .pass_beat (pass_beat)
    );

    daf_cmp #(.NUM_MC(NUM_MC)) u_cmp (
        .addr    (cand_addr),
        .station (cfg_station),
        .mcast   (cfg_mcast),
        .mcast_en(cfg_mcast_en),
        .cls     (cls),
        .accept  (accept_now)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            dec_q  <= '0;
            beat_q <= '0;
            pay_q  <= 1'b0;
        end else begin
            dec_q.valid <= last_dst;
            if (last_dst) begin
                dec_q.accept <= accept_now;
                dec_q.cls    <= cls;
                dec_q.addr   <= cand_addr;
            end
            beat_q.valid <= pass_beat.valid;
            if (pass_beat.valid) begin
                beat_q.tag  <= pass_beat.tag;
                beat_q.data <= pass_beat.data;
            end
            pay_q <= pass_beat.valid && (pass_beat.tag == TAG_PAY);
        end
    end

    assign dec_valid     = dec_q.valid;
    assign dec_accept    = dec_q.accept;
    assign dec_class     = dec_q.cls;
    assign dec_addr      = dec_q.addr;
    assign out_valid     = beat_q.valid;
    assign out_tag       = beat_q.tag;
    assign out_data      = beat_q.data;
    assign payload_valid = pay_q;

    // R8
    pay_flag_chk: assert property (@(posedge clk) disable iff (rst)
        payload_valid == (out_valid && out_tag == TAG_PAY));

    // R2
    dec_cls_chk: assert property (@(posedge clk) disable iff (rst)
        dec_valid |-> (dec_accept == (dec_class != HIT_NONE)));

    // R5
    rej_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && !dec_accept) |-> !out_valid);
endmodule

// File: tb/sim_dst_addr_filter.sv
module sim_dst_addr_filter;
    localparam int NMC = 4;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           in_valid = 1'b0;
    logic           in_sof = 1'b0;
    logic [7:0]     in_data = '0;
    logic [47:0]    cfg_station = '0;
    logic [NMC*48-1:0] cfg_mcast = '0;
    logic [NMC-1:0] cfg_mcast_en = '0;
    logic           dec_valid, dec_accept, out_valid, payload_valid;
    logic [1:0]     dec_class, out_tag;
    logic [47:0]    dec_addr;
    logic [7:0]     out_data;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    localparam logic [47:0] STA = 48'h0211_2233_4455;
    localparam logic [47:0] MC0 = 48'h0100_5E00_0001;
    localparam logic [47:0] MC1 = 48'h0100_5E00_0002;
    localparam logic [47:0] MC2 = 48'h3333_0000_0010;
    localparam logic [47:0] MC3 = 48'h0180_C200_000E;
    localparam logic [47:0] BC  = 48'hFFFF_FFFF_FFFF;
    localparam logic [47:0] SRC = 48'h00A0_B0C0_D0E0;

    dst_addr_filter #(.NUM_MC(NMC)) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof), .in_data(in_data),
        .cfg_station(cfg_station), .cfg_mcast(cfg_mcast), .cfg_mcast_en(cfg_mcast_en),
        .dec_valid(dec_valid), .dec_accept(dec_accept), .dec_class(dec_class),
        .dec_addr(dec_addr), .out_valid(out_valid), .out_tag(out_tag),
        .out_data(out_data), .payload_valid(payload_valid)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic push(input logic v, input logic s, input logic [7:0] d);
        in_valid = v;
        in_sof   = s;
        in_data  = d;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        in_sof   = 1'b0;
    endtask

    function automatic logic [7:0] frame_byte(input logic [47:0] da, input int i);
        if (i < 6)       return da[47-8*i -: 8];
        else if (i < 12) return SRC[47-8*(i-6) -: 8];
        else if (i < 14) return (i == 12) ? 8'h00 : 8'h2E;
        else             return 8'(i * 7 + 3);
    endfunction

    function automatic logic [1:0] exp_tag(input int i);
        if (i < 12)      return 2'd1;
        else if (i < 14) return 2'd2;
        else             return 2'd3;
    endfunction

    // One whole frame; checks outputs after every byte and every gap cycle.
    task automatic send_frame(input logic [47:0] da, input int npay, input int gap,
                              input bit acc, input logic [1:0] cls, input string req);
        for (int i = 0; i < 14 + npay; i++) begin
            logic [7:0] b;
            b = frame_byte(da, i);
            push(1'b1, i == 0, b);
            if (i < 5) begin
                chk(!dec_valid && !out_valid, req, "quiet before decision",
                    {dec_valid, out_valid}, 0);
            end else if (i == 5) begin
                chk(dec_valid == 1'b1, req, "dec_valid", dec_valid, 1);
                chk(dec_accept == acc, req, "dec_accept", dec_accept, acc);
                chk(dec_class == cls, req, "dec_class", dec_class, cls);
                chk(dec_addr == da, req, "dec_addr (R11 byte order)", dec_addr, da);
                chk(!out_valid, req, "no out on decision", out_valid, 0);
            end else begin
                chk(!dec_valid, "R12", "single decision", dec_valid, 0);
                chk(out_valid == acc, acc ? "R7" : "R5", "out_valid", out_valid, acc);
                if (acc) begin
                    chk(out_tag == exp_tag(i), "R7", "out_tag", out_tag, exp_tag(i));
                    chk(out_data == b, "R7", "out_data", out_data, b);
                end
                chk(payload_valid == (acc && i >= 14), "R8", "payload_valid",
                    payload_valid, acc && i >= 14);
            end
            for (int g = 0; g < gap; g++) begin
                push(1'b0, 1'b0, 8'hEE);
                chk(!dec_valid && !out_valid && !payload_valid, "R10", "idle gap",
                    {dec_valid, out_valid, payload_valid}, 0);
            end
        end
        push(1'b0, 1'b0, 8'h00);
    endtask

    task automatic t_reset();
        chk(!dec_valid && !dec_accept && dec_class == 0 && dec_addr == 0, "R1",
            "decision reset", {dec_valid, dec_accept, dec_class}, 0);
        chk(!out_valid && out_tag == 0 && out_data == 0 && !payload_valid, "R1",
            "stream reset", {out_valid, out_tag, out_data, payload_valid}, 0);
    endtask

    task automatic t_unique();
        send_frame(STA, 5, 0, 1'b1, 2'd1, "R2");
    endtask

    task automatic t_mcast();
        send_frame(MC2, 2, 0, 1'b1, 2'd2, "R3");
        send_frame(MC1, 2, 0, 1'b0, 2'd0, "R3");
    endtask

    task automatic t_bcast();
        send_frame(BC, 3, 0, 1'b1, 2'd3, "R4");
    endtask

    task automatic t_reject();
        send_frame(48'h0A0B_0C0D_0E0F, 4, 0, 1'b0, 2'd0, "R5");
    endtask

    task automatic t_priority();
        cfg_mcast[47:0] = BC;
        push(1'b0, 1'b0, 8'h00);
        send_frame(BC, 1, 0, 1'b1, 2'd3, "R6");
        cfg_station = MC3;
        push(1'b0, 1'b0, 8'h00);
        send_frame(MC3, 1, 0, 1'b1, 2'd1, "R6");
        cfg_station   = STA;
        cfg_mcast[47:0] = MC0;
        push(1'b0, 1'b0, 8'h00);
    endtask

    task automatic t_gaps();
        send_frame(MC0, 3, 2, 1'b1, 2'd2, "R10");
    endtask

    task automatic t_restart();
        // Restart during a destination field.
        for (int i = 0; i < 3; i++) push(1'b1, i == 0, frame_byte(STA, i));
        send_frame(BC, 1, 0, 1'b1, 2'd3, "R9");
        // Restart during an accepted frame with a non-matching destination.
        for (int i = 0; i < 8; i++) push(1'b1, i == 0, frame_byte(STA, i));
        chk(out_valid == 1'b1, "R9", "accepted before restart", out_valid, 1);
        for (int i = 0; i < 9; i++) begin
            push(1'b1, i == 0, frame_byte(48'h1234_5678_9ABC, i));
            chk(!out_valid && !payload_valid, "R9", "no pass after restart",
                out_valid, 0);
            if (i == 5) chk(dec_valid && !dec_accept, "R9", "restart decision",
                            {dec_valid, dec_accept}, 2);
        end
        push(1'b0, 1'b0, 8'h00);
    endtask

    task automatic t_short();
        for (int i = 0; i < 4; i++) begin
            push(1'b1, i == 0, frame_byte(STA, i));
            chk(!dec_valid, "R12", "short frame byte", dec_valid, 0);
        end
        for (int i = 0; i < 4; i++) begin
            push(1'b0, 1'b0, 8'h00);
            chk(!dec_valid && !out_valid, "R12", "short frame no decision",
                {dec_valid, out_valid}, 0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        cfg_station  = STA;
        cfg_mcast    = {MC3, MC2, MC1, MC0};
        cfg_mcast_en = 4'b1101;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_unique();
        t_mcast();
        t_bcast();
        t_reject();
        t_priority();
        t_gaps();
        t_restart();
        t_short();
        t_unique();
        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule